// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a master-only synchronous serial port. Software reaches it through a simple word-addressed register bus. Words written to the data register enter an eight-entry transmit queue. A shift engine sends each word out MSB first in SPI mode 0 and stores the word returned on the input line in an eight-entry receive queue. Software then reads the received words from the same data register. A frame-size field sets the word width from 4 to 16 bits, and every transmitted and received word is masked to that width.

The engine starts a frame only while the transmit queue holds data and the receive queue has room. When the receive queue fills, transmission stalls until software reads a word; no received word is ever dropped. A loopback mode routes each transmitted word straight into the receive queue. In this mode the frame timing still runs, but the serial outputs stay idle. A single interrupt line is raised from two queue-level conditions, each of which can be masked. The bit clock comes from an even prescaler and a rate multiplier.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the masked interrupt register (0x1C) reads 0 and `irq` is low.
- R2: Control 0 (offset 0x00) bits [3:0] hold F, and the frame width is F+1 bits. A word written to the data register (0x08) is stored ANDed with (1<<(F+1))-1, using the F in force at the time of the write. In loopback, each word reads back from the data register unchanged and in write order.
- R3: A data-register write while the transmit queue holds 8 words has no effect. That word never appears in the receive queue.
- R4: A data-register read while the receive queue is empty returns 0.
- R5: While the enable bit (control 1, offset 0x04, bit 1) is clear, no frame starts: queued words stay queued and `cs_n` stays high.
- R6: Status bits: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy (the transmit queue holds data).
- R7: Raw interrupt bit 2 is set while the receive queue holds 4 or more words. Raw interrupt bit 3 is set while the transmit queue holds 4 or fewer words. The mask register is at offset 0x14, the masked register reads raw AND mask, and `irq` is high when that value is nonzero.
- R8: A frame starts only while the receive queue has room. With the receive queue full, transmit words stay queued until a data read frees an entry, after which exactly one more frame runs.
- R9: In normal mode (control 1 bit 0 clear), `mosi` presents the word MSB first. It changes while `sclk` is low, and `miso` is sampled on each rising `sclk`. The sampled F+1 bits are stored as the received word.
- R10: In loopback mode (control 1 bit 0 set), `sclk` and `mosi` stay low and `cs_n` stays high during frames.
- R11: The `sclk` high and low phases each last (P/2)×(1+S) clock cycles. S is control 0 bits [15:8]. P is the prescaler (offset 0x10, 8 bits) with bit 0 cleared, and raised to 2 if the result is below 2.
- R12: Offsets 0xFE0 to 0xFFC read, one per word, 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: Between consecutive frames `cs_n` stays high for at least one full `sclk` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial bit clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue count shows up within one bus access. The status flags and the raw interrupt bits decode the counts directly, so an off-by-one shows at the 4-entry threshold or at the full and empty edges, and a lost or duplicated pointer update returns words out of order on the next data read. A fault in the shift engine shows at the serial pins during the frame it affects. A wrong bit index or sampling point corrupts the word captured by the bench's slave model or the word returned on the next read. A wrong timer load shows as an `sclk` phase or chip-select gap of the wrong length in the very next frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int OFF_CTRL0  = 'h000;
  localparam int OFF_CTRL1  = 'h004;
  localparam int OFF_DATA   = 'h008;
  localparam int OFF_STAT   = 'h00C;
  localparam int OFF_PSC    = 'h010;
  localparam int OFF_MASK   = 'h014;
  localparam int OFF_RAW    = 'h018;
  localparam int OFF_MIS    = 'h01C;
  localparam int OFF_IDBASE = 'hFE0;

  // control 1 bit positions
  localparam int C1_LOOP = 0;
  localparam int C1_EN   = 1;

  // status bit positions
  localparam int ST_TEMPTY = 0;
  localparam int ST_TNFULL = 1;
  localparam int ST_RNEMPT = 2;
  localparam int ST_RFULL  = 3;
  localparam int ST_BUSY   = 4;

  // interrupt bit positions
  localparam int IRQ_RXLVL = 2;
  localparam int IRQ_TXLVL = 3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_GAP} eng_state_t;

  // Mask keeping the low (fsz+1) bits of a word.
  function automatic logic [15:0] frame_mask(input logic [3:0] fsz);
    logic [16:0] m;
    m = (17'd1 << ({1'b0, fsz} + 5'd1)) - 17'd1;
    return m[15:0];
  endfunction

  // Clock cycles per sclk phase: (even prescaler, min 2) / 2 * (1 + rate).
  function automatic logic [15:0] phase_len(input logic [7:0] psc, input logic [7:0] rate);
    logic [7:0] ev;
    ev = psc & 8'hFE;
    if (ev < 8'd2) ev = 8'd2;
    return 16'(ev[7:1]) * (16'(rate) + 16'd1);
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h22;
      3'd1: return 8'h10;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3 R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic [3:0]    fsz,
  input  logic [15:0]   half,
  input  logic          loopback,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          idle
);
  localparam int BW = $clog2(DW);
  localparam int TW = 17;

  eng_state_t    state;
  logic [TW-1:0] timer;
  logic [15:0]   half_l;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] word;
  logic [DW-1:0] acc;
  logic          lb_l;
  logic          in_frame;
  logic          tick;
  logic          sample_bit;

  assign tick       = (timer == '0);
  assign in_frame   = (state == ENG_LOW) || (state == ENG_HIGH);
  assign sample_bit = lb_l ? word[bit_idx] : miso;

  assign idle    = (state == ENG_IDLE);
  assign done    = (state == ENG_HIGH) && tick && (bit_idx == '0);
  assign rx_word = acc;
  assign cs_n    = !(in_frame && !lb_l);
  assign sclk    = (state == ENG_HIGH) && !lb_l;
  assign mosi    = in_frame && !lb_l && word[bit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      timer   <= '0;
      half_l  <= 16'd1;
      bit_idx <= '0;
      word    <= '0;
      acc     <= '0;
      lb_l    <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          state   <= ENG_LOW;
          half_l  <= half;
          timer   <= {1'b0, half} - TW'(1);
          bit_idx <= BW'(fsz);
          word    <= tx_word;
          acc     <= '0;
          lb_l    <= loopback;
        end
        ENG_LOW: if (tick) begin
          state <= ENG_HIGH;
          timer <= {1'b0, half_l} - TW'(1);
          acc   <= {acc[DW-2:0], sample_bit};
        end else timer <= timer - TW'(1);
        ENG_HIGH: if (tick) begin
          if (bit_idx == '0) begin
            state <= ENG_GAP;
            timer <= {half_l, 1'b0} - TW'(1);
          end else begin
            state   <= ENG_LOW;
            bit_idx <= bit_idx - BW'(1);
            timer   <= {1'b0, half_l} - TW'(1);
          end
        end else timer <= timer - TW'(1);
        default: if (tick) state <= ENG_IDLE;
                 else timer <= timer - TW'(1);
      endcase
    end
  end

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> idle);
  // R9
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);
  // R10
  lb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_l && !idle) |-> (cs_n && !sclk && !mosi));
  // R13
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int AW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  input  logic          miso,
  output logic          irq
);
  localparam int CW    = $clog2(FIFO_DEPTH) + 1;
  localparam int LEVEL = FIFO_DEPTH / 2;

  logic [DW-1:0] ctrl0;
  logic [3:0]    ctrl1;
  logic [7:0]    psc;
  logic [3:0]    imask;

  logic [DW-1:0] tx_head, rx_head, eng_rx;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, rx_pop, eng_start, eng_done, eng_idle;
  logic          wr_hit, rd_hit;
  logic [4:0]    status;
  logic [3:0]    raw_irq;
  logic [DW-1:0] cur_mask;

  assign wr_hit   = bus_sel && bus_wr;
  assign rd_hit   = bus_sel && !bus_wr;
  assign cur_mask = frame_mask(ctrl0[3:0]);

  assign tx_push   = wr_hit && (bus_addr == AW'(OFF_DATA)) && !tx_full;
  assign rx_pop    = rd_hit && (bus_addr == AW'(OFF_DATA)) && !rx_empty;
  assign eng_start = eng_idle && ctrl1[C1_EN] && !tx_empty && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0 <= '0;
      ctrl1 <= '0;
      psc   <= '0;
      imask <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        AW'(OFF_CTRL0): ctrl0 <= bus_wdata;
        AW'(OFF_CTRL1): ctrl1 <= bus_wdata[3:0];
        AW'(OFF_PSC):   psc   <= bus_wdata[7:0];
        AW'(OFF_MASK):  imask <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(bus_wdata & cur_mask),
    .pop(eng_start), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_done), .wdata(eng_rx),
    .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  ssp_shifter #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .tx_word(tx_head),
    .fsz(ctrl0[3:0]), .half(phase_len(psc, ctrl0[15:8])),
    .loopback(ctrl1[C1_LOOP]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .done(eng_done), .rx_word(eng_rx), .idle(eng_idle)
  );

  always_comb begin
    status = '0;
    status[ST_TEMPTY] = tx_empty;
    status[ST_TNFULL] = !tx_full;
    status[ST_RNEMPT] = !rx_empty;
    status[ST_RFULL]  = rx_full;
    status[ST_BUSY]   = !tx_empty;
    raw_irq = '0;
    raw_irq[IRQ_RXLVL] = (rx_cnt >= CW'(LEVEL));
    raw_irq[IRQ_TXLVL] = (tx_cnt <= CW'(LEVEL));
  end

  assign irq = |(raw_irq & imask);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr >= AW'(OFF_IDBASE)) begin
      bus_rdata = DW'(id_byte(bus_addr[4:2]));
    end else begin
      case (bus_addr)
        AW'(OFF_CTRL0): bus_rdata = ctrl0;
        AW'(OFF_CTRL1): bus_rdata = DW'(ctrl1);
        AW'(OFF_DATA):  bus_rdata = rx_empty ? '0 : rx_head;
        AW'(OFF_STAT):  bus_rdata = DW'(status);
        AW'(OFF_PSC):   bus_rdata = DW'(psc);
        AW'(OFF_MASK):  bus_rdata = DW'(imask);
        AW'(OFF_RAW):   bus_rdata = DW'(raw_irq);
        AW'(OFF_MIS):   bus_rdata = DW'(raw_irq & imask);
        default:        bus_rdata = '0;
      endcase
    end
  end

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl1[C1_EN] && eng_idle) |=> eng_idle);
  // R8
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_idle) |=> !eng_done);

endmodule

// File: tb/tb_ssp_ctrl.sv
module tb_ssp_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, cs_n, irq;
  logic        miso = 0;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  logic [15:0] txexp_q[$];
  logic [15:0] resp_q[$];

  int nbits = 8;
  logic [15:0] cur_resp = '0, mosi_sh = '0;
  int bitpos = 0;
  bit in_frame = 0, seen_rise = 0;
  int hi_start = 0, last_high = 0, cs_rise = 0, last_gap = 0;
  int sclk_edges = 0, cs_falls = 0;

  ssp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model on the serial pins
  always @(negedge cs_n) begin
    if (rst_n) begin
      cs_falls++;
      if (seen_rise) last_gap = cyc - cs_rise;
      cur_resp = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0;
      bitpos = nbits - 1;
      miso = cur_resp[bitpos];
      mosi_sh = '0;
      in_frame = 1;
    end
  end
  always @(posedge sclk) begin
    sclk_edges++;
    mosi_sh = {mosi_sh[14:0], mosi};
    hi_start = cyc;
  end
  always @(negedge sclk) begin
    last_high = cyc - hi_start;
    if (bitpos > 0) bitpos--;
    miso = cur_resp[bitpos];
  end
  always @(posedge cs_n) begin
    if (in_frame) begin
      logic [15:0] e;
      e = (txexp_q.size() > 0) ? txexp_q.pop_front() : 16'hDEAD;
      check(mosi_sh == e, "R9 mosi word", mosi_sh, e);
      in_frame = 0;
      cs_rise = cyc;
      seen_rise = 1;
    end
  end

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic expect_reg(input int a, input logic [15:0] e, input string req);
    logic [15:0] v;
    bus_read(a, v);
    check(v == e, req, v, e);
  endtask

  // driver: queue a word and what it should come back as
  task automatic send(input logic [15:0] w, input logic [15:0] resp, input logic [15:0] mask, input bit lb);
    if (lb) exp_q.push_back(w & mask);
    else begin
      exp_q.push_back(resp & mask);
      txexp_q.push_back(w & mask);
      resp_q.push_back(resp);
    end
    bus_write('h08, w);
  endtask

  // monitor: pop expected words as the design delivers them
  task automatic drain(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [15:0] s, v, e;
      int guard = 0;
      s = 0;
      while (!s[2] && guard < 4000) begin bus_read('h0C, s); guard++; end
      bus_read('h08, v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hBEEF;
      check(v == e, req, v, e);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    expect_reg('h0C, 16'h03, "R1 R6 status after reset");
    expect_reg('h18, 16'h08, "R1 raw irq after reset");
    expect_reg('h1C, 16'h00, "R1 masked irq after reset");
    check(irq == 0, "R1 irq low", irq, 0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] idb[8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      expect_reg('hFE0 + 4 * i, 16'(idb[i]), "R12 id byte");
    end
    expect_reg('h08, 16'h0, "R4 empty read");

    // disabled: words queue, nothing moves
    bus_write('h00, 16'h0007);
    bus_write('h10, 16'h0002);
    for (int i = 0; i < 3; i++) send(16'hA5C0 + 16'(i * 37), 0, 16'hFF, 1);
    expect_reg('h0C, 16'h12, "R6 status 3 queued");
    wait_cycles(60);
    expect_reg('h0C, 16'h12, "R5 still queued when disabled");
    check(cs_falls == 0, "R5 cs_n stayed high", cs_falls, 0);
    for (int i = 3; i < 8; i++) send(16'hA5C0 + 16'(i * 37), 0, 16'hFF, 1);
    expect_reg('h0C, 16'h10, "R6 tx full status");
    expect_reg('h18, 16'h00, "R7 raw irq tx full");
    bus_write('h08, 16'hAB0F);   // R3: ignored while full

    // loopback run
    bus_write('h04, 16'h0003);
    begin
      int g = 0;
      v = 0;
      while (!v[3] && g < 2000) begin bus_read('h0C, v); g++; end
    end
    wait_cycles(5);
    expect_reg('h0C, 16'h0F, "R6 rx full tx empty");
    expect_reg('h18, 16'h0C, "R7 raw irq both levels");
    check(irq == 0, "R7 irq masked off", irq, 0);
    bus_write('h14, 16'h0004);
    @(negedge clk);
    check(irq == 1, "R7 irq with rx mask", irq, 1);
    expect_reg('h1C, 16'h04, "R7 masked irq");
    check(sclk_edges == 0 && cs_falls == 0, "R10 pins idle in loopback", sclk_edges + cs_falls, 0);
    drain(8, "R2 loopback masked word");
    expect_reg('h08, 16'h0, "R3 ignored word absent");
    expect_reg('h0C, 16'h03, "R6 empty again");
    check(irq == 0, "R7 irq drops", irq, 0);

    // stall when receive queue full
    for (int i = 0; i < 8; i++) send(16'h1100 + 16'(i), 0, 16'hFF, 1);
    wait_cycles(250);
    for (int i = 8; i < 16; i++) send(16'h1100 + 16'(i), 0, 16'hFF, 1);
    wait_cycles(100);
    expect_reg('h0C, 16'h1C, "R8 stalled both full");
    drain(1, "R8 first word");
    wait_cycles(60);
    expect_reg('h0C, 16'h1E, "R8 exactly one more frame");
    drain(15, "R8 remaining words");
    expect_reg('h0C, 16'h03, "R8 all drained");
    check(sclk_edges == 0 && cs_falls == 0, "R10 pins idle in loopback", sclk_edges + cs_falls, 0);

    // normal mode, 12-bit frames, prescaler 0 forced to 2
    bus_write('h04, 16'h0002);
    bus_write('h00, 16'h000B);
    bus_write('h10, 16'h0000);
    nbits = 12;
    send(16'hFABC, 16'h05A5, 16'h0FFF, 0);
    send(16'h7123, 16'hFF0F, 16'h0FFF, 0);
    drain(2, "R9 miso word");
    check(last_high == 1, "R11 phase with psc forced 2", last_high, 1);

    // slower clock: psc 5 -> 4, rate 2 -> phase 6
    bus_write('h00, 16'h0207);
    bus_write('h10, 16'h0005);
    nbits = 8;
    send(16'h00C3, 16'h003C, 16'h00FF, 0);
    send(16'h0081, 16'h0099, 16'h00FF, 0);
    drain(2, "R9 miso word slow");
    check(last_high == 6, "R11 sclk high phase", last_high, 6);
    check(last_gap >= 12, "R13 cs gap one period", last_gap, 12);

    wait_cycles(20);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule